// File: doc/BRIEF.md
# Instruction decode group allocator

This block sits between a pre-decoded instruction window and the micro-op queue of a processor front end. It accepts a window of up to five instructions at a time. Each instruction carries a tag, a micro-op count, a flag saying it can fuse with a following branch, and a flag saying it is a conditional branch. Every cycle the block chooses which instructions go through the decoder slots and puts their micro-ops on a set of output lanes.

Grouping follows the position rules of one complex decoder followed by simple ones. Only the first slot takes an instruction with more than one micro-op. An instruction with more micro-ops than the per-cycle limit goes to a small sequencer, which streams its micro-ops over several cycles while the decoder slots wait. A fusible instruction that closes a group is kept back for one step so that it can join a branch arriving next. A fusible instruction directly followed by a branch leaves as one fused micro-op.

Top module: `decode_group_alloc`

## Requirements
- R1: A group that contains a multi-uop instruction emits at most MAXU (4) micro-ops. A group made only of single-uop instructions may use all NDEC (5) decoder slots, giving five micro-ops on lanes 0..4 with uop index 0.
- R2: An instruction of 2..MAXU micro-ops is decoded only in the first slot. Its micro-ops occupy lanes 0..n-1, and the uop index field equals the lane number. A multi-uop instruction that is reached in a later slot ends the current group and leads the next one. Valid lanes always form a prefix starting at lane 0.
- R3: Single-uop instructions after a multi-uop one fill the group only up to MAXU micro-ops in total, which gives the patterns 2-1-1, 3-1 and 4.
- R4: An instruction of more than MAXU micro-ops is taken only in the first slot. Its micro-ops leave MAXU per accepted cycle, with the microcode flag set and uop indices rising from 0, and the remainder leaves in the last cycle. No decoded instruction is emitted until it has finished.
- R5: A single-uop fusible instruction directly followed by a single-uop branch gives one lane. That lane has the fused flag set and carries the fusible instruction's tag. The branch uses no lane of its own.
- R6: A fusible instruction that would be the last one taken in a cycle is held back. This happens when nothing follows it in the window, or when the following instruction does not fit the group. If the next instruction is a branch, it fuses with it on lane 0 of a later cycle, including across windows. While it is held alone, no micro-op is emitted.
- R7: A held fusible instruction whose successor is not a branch is emitted unfused on lane 0 and heads the next group.
- R8: While out_valid is high and out_ready is low, every output lane stays unchanged and nothing is consumed.
- R9: After reset, in_ready is 1 and out_valid is 0. in_ready is 1 only when the window buffer is empty. A window is taken when in_valid and in_ready are both high, and it holds in_num instructions starting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window offered |
| in_ready | output | 1 | Window buffer empty, window accepted |
| in_num | input | 3 | Number of instructions in the window, filled from slot 0 |
| in_tag | input | NSLOT*TAGW | Per-slot instruction tag |
| in_nuop | input | NSLOT*UCW | Per-slot micro-op count (1 or more) |
| in_fus | input | NSLOT | Per-slot fusible flag |
| in_br | input | NSLOT | Per-slot conditional-branch flag |
| out_valid | output | 1 | At least one lane valid |
| out_ready | input | 1 | Consumer takes the lanes |
| out_lane_vld | output | NDEC | Lane valid bits |
| out_lane_tag | output | NDEC*TAGW | Tag of the instruction for each lane |
| out_lane_idx | output | NDEC*UCW | Micro-op index within its instruction |
| out_lane_fused | output | NDEC | Lane is a fused pair |
| out_lane_ucode | output | NDEC | Lane comes from the microcode sequencer |

## Verification
Two functions can act on the same cycle. In one, a fusible instruction is held back while the group in front of it closes on the micro-op limit. In the other, that held instruction is released when a new window arrives. The bench provokes the first case with a three-uop instruction followed by a fusible one. It provokes the second with a lone fusible instruction followed by a window that starts with a branch, and with one that starts with a plain instruction. It then checks lane by lane, in the cycle after the load, whether a fused lane or an unfused head appears.

// File: rtl/dga_pkg.sv
package dga_pkg;
  parameter int TAGW = 8;
  parameter int UCW  = 4;

  typedef struct packed {
    logic [TAGW-1:0] tag;
    logic [UCW-1:0]  nuop;
    logic            fus;
    logic            br;
  } insn_t;

  typedef struct packed {
    logic            vld;
    logic [TAGW-1:0] tag;
    logic [UCW-1:0]  idx;
    logic            fused;
    logic            ucode;
  } lane_t;

  function automatic lane_t mk_lane(logic [TAGW-1:0] t, logic [UCW-1:0] i,
                                    logic f, logic c);
    lane_t l;
    l.vld   = 1'b1;
    l.tag   = t;
    l.idx   = i;
    l.fused = f;
    l.ucode = c;
    return l;
  endfunction
endpackage

// File: rtl/dga_group_walk.sv
module dga_group_walk
  import dga_pkg::*;
#(
  parameter int NC   = 6,
  parameter int NDEC = 5,
  parameter int MAXU = 4,
  localparam int CW  = $clog2(NC + 2)
) (
  input  insn_t         cand [NC],
  input  logic [NC-1:0] cand_vld,
  input  logic          held0,
  output lane_t         lane [NDEC],
  output logic [CW-1:0] used,
  output logic          hold_n,
  output insn_t         hold_insn,
  output logic          uc_start,
  output insn_t         uc_insn
);
  insn_t cx [NC+1];
  logic  vx [NC+1];

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      cx[i] = cand[i];
      vx[i] = cand_vld[i];
    end
    cx[NC] = '0;
    vx[NC] = 1'b0;
  end

  // walk the candidates in order, filling decoder slots and lanes
  always_comb begin
    int   s, u, cap;
    logic stop, skip, multi, nxt_ok, nxt_fit;
    for (int i = 0; i < NDEC; i++) lane[i] = '0;
    used = '0; hold_n = 1'b0; hold_insn = '0;
    uc_start = 1'b0; uc_insn = '0;
    s = 0; u = 0; cap = NDEC;
    stop = 1'b0; skip = 1'b0; multi = 1'b0; nxt_ok = 1'b0; nxt_fit = 1'b0;
    for (int k = 0; k < NC; k++) begin
      if (skip) begin
        skip = 1'b0;
      end else if (!stop) begin
        if (!vx[k]) begin
          stop = 1'b1;
        end else if (int'(cx[k].nuop) > MAXU) begin
          if (s == 0) begin
            uc_start = 1'b1;
            uc_insn  = cx[k];
            for (int j = 0; j < MAXU; j++)
              lane[j] = mk_lane(cx[k].tag, UCW'(j), 1'b0, 1'b1);
            used = CW'(k + 1);
          end
          stop = 1'b1;
        end else if (int'(cx[k].nuop) > 1) begin
          if (s == 0) begin
            for (int j = 0; j < MAXU; j++)
              if (j < int'(cx[k].nuop))
                lane[j] = mk_lane(cx[k].tag, UCW'(j), 1'b0, 1'b0);
            s = 1; u = int'(cx[k].nuop); multi = 1'b1;
            used = CW'(k + 1);
          end else begin
            stop = 1'b1;
          end
        end else begin
          cap = multi ? MAXU : NDEC;
          if (s >= NDEC || u + 1 > cap) begin
            stop = 1'b1;
          end else begin
            nxt_ok = vx[k+1];
            if (cx[k].fus && nxt_ok && cx[k+1].br && cx[k+1].nuop == UCW'(1)) begin
              lane[u] = mk_lane(cx[k].tag, '0, 1'b1, 1'b0);
              u = u + 1; s = s + 1;
              used = CW'(k + 2);
              skip = 1'b1;
            end else begin
              nxt_fit = nxt_ok && (cx[k+1].nuop == UCW'(1)) &&
                        (s + 1 < NDEC) && (u + 2 <= cap);
              if (cx[k].fus && (!nxt_ok || (!nxt_fit && !(k == 0 && held0)))) begin
                hold_n    = 1'b1;
                hold_insn = cx[k];
                used      = CW'(k + 1);
                stop      = 1'b1;
              end else begin
                lane[u] = mk_lane(cx[k].tag, '0, 1'b0, 1'b0);
                u = u + 1; s = s + 1;
                used = CW'(k + 1);
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dga_useq.sv
module dga_useq
  import dga_pkg::*;
#(
  parameter int NDEC = 5,
  parameter int MAXU = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  insn_t start_insn,
  input  logic  adv,
  output logic  busy,
  output lane_t lane [NDEC]
);
  logic [UCW-1:0]  rem_q, rem_d, idx_q, idx_d, take;
  logic [TAGW-1:0] tag_q, tag_d;
  logic            en;

  assign busy = (rem_q != '0);
  assign take = (int'(rem_q) > MAXU) ? UCW'(MAXU) : rem_q;

  always_comb begin
    rem_d = rem_q; idx_d = idx_q; tag_d = tag_q;
    en    = 1'b0;
    if (start) begin
      en    = 1'b1;
      rem_d = start_insn.nuop - UCW'(MAXU);
      idx_d = UCW'(MAXU);
      tag_d = start_insn.tag;
    end else if (busy && adv) begin
      en    = 1'b1;
      rem_d = rem_q - take;
      idx_d = idx_q + take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
      tag_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      idx_q <= idx_d;
      tag_q <= tag_d;
    end
  end

  always_comb begin
    for (int j = 0; j < NDEC; j++) begin
      lane[j] = '0;
      if (busy && j < MAXU && j < int'(rem_q))
        lane[j] = mk_lane(tag_q, idx_q + UCW'(j), 1'b0, 1'b1);
    end
  end

  // R4: the last chunk empties the sequencer
  a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
    busy && adv && int'(rem_q) <= MAXU |=> !busy);
  // R4: no progress without acceptance
  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !adv |=> $stable(rem_q) && $stable(idx_q));
  // R4: a new long instruction never starts while one is streaming
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/decode_group_alloc.sv
module decode_group_alloc
  import dga_pkg::*;
#(
  parameter int NSLOT = 5,
  parameter int NDEC  = 5,
  parameter int MAXU  = 4,
  localparam int NC   = NSLOT + 1,
  localparam int PW   = $clog2(NSLOT + 1),
  localparam int CW   = $clog2(NC + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [PW-1:0]         in_num,
  input  logic [NSLOT*TAGW-1:0] in_tag,
  input  logic [NSLOT*UCW-1:0]  in_nuop,
  input  logic [NSLOT-1:0]      in_fus,
  input  logic [NSLOT-1:0]      in_br,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [NDEC-1:0]       out_lane_vld,
  output logic [NDEC*TAGW-1:0]  out_lane_tag,
  output logic [NDEC*UCW-1:0]   out_lane_idx,
  output logic [NDEC-1:0]       out_lane_fused,
  output logic [NDEC-1:0]       out_lane_ucode
);
  insn_t         buf_q [NSLOT];
  insn_t         buf_d [NSLOT];
  logic [PW-1:0] num_q, num_d, head_q, head_d;
  logic          hold_vld_q, hold_vld_d;
  insn_t         hold_q, hold_d;
  logic          en;

  insn_t         cand [NC];
  logic [NC-1:0] cand_vld;
  lane_t         w_lane [NDEC];
  lane_t         s_lane [NDEC];
  lane_t         o_lane [NDEC];
  logic [CW-1:0] w_used;
  logic          w_hold, w_uc;
  insn_t         w_hold_insn, w_uc_insn;
  logic          uc_busy, adv_dec, take_in;

  assign in_ready = (head_q >= num_q);
  assign take_in  = in_valid && in_ready;

  // candidate list: held instruction first, then unconsumed buffer entries
  always_comb begin
    int idx;
    for (int i = 0; i < NC; i++) begin
      cand[i] = '0;
      cand_vld[i] = 1'b0;
      idx = hold_vld_q ? int'(head_q) + i - 1 : int'(head_q) + i;
      if (hold_vld_q && i == 0) begin
        cand[i] = hold_q;
        cand_vld[i] = 1'b1;
      end else if (idx >= 0 && idx < NSLOT && idx < int'(num_q)) begin
        cand[i] = buf_q[idx];
        cand_vld[i] = 1'b1;
      end
    end
  end

  dga_group_walk #(.NC(NC), .NDEC(NDEC), .MAXU(MAXU)) u_walk (
    .cand(cand), .cand_vld(cand_vld), .held0(hold_vld_q),
    .lane(w_lane), .used(w_used), .hold_n(w_hold), .hold_insn(w_hold_insn),
    .uc_start(w_uc), .uc_insn(w_uc_insn)
  );

  dga_useq #(.NDEC(NDEC), .MAXU(MAXU)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(w_uc && adv_dec), .start_insn(w_uc_insn),
    .adv(out_ready), .busy(uc_busy), .lane(s_lane)
  );

  always_comb begin
    for (int j = 0; j < NDEC; j++) o_lane[j] = uc_busy ? s_lane[j] : w_lane[j];
  end

  for (genvar j = 0; j < NDEC; j++) begin : g_lane
    assign out_lane_vld[j]                   = o_lane[j].vld;
    assign out_lane_tag[j*TAGW +: TAGW]      = o_lane[j].tag;
    assign out_lane_idx[j*UCW +: UCW]        = o_lane[j].idx;
    assign out_lane_fused[j]                 = o_lane[j].fused;
    assign out_lane_ucode[j]                 = o_lane[j].ucode;
  end

  assign out_valid = |out_lane_vld;
  assign adv_dec   = !uc_busy && (!out_valid || out_ready);

  // next state
  always_comb begin
    buf_d = buf_q; num_d = num_q; head_d = head_q;
    hold_vld_d = hold_vld_q; hold_d = hold_q;
    en = adv_dec || take_in;
    if (adv_dec) begin
      head_d     = head_q + PW'(int'(w_used) - int'(hold_vld_q));
      hold_vld_d = w_hold;
      hold_d     = w_hold ? w_hold_insn : hold_q;
    end
    if (take_in) begin
      for (int i = 0; i < NSLOT; i++) begin
        buf_d[i].tag  = in_tag[i*TAGW +: TAGW];
        buf_d[i].nuop = in_nuop[i*UCW +: UCW];
        buf_d[i].fus  = in_fus[i];
        buf_d[i].br   = in_br[i];
      end
      num_d  = in_num;
      head_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) buf_q[i] <= '0;
      num_q      <= '0;
      head_q     <= '0;
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
    end else if (en) begin
      buf_q      <= buf_d;
      num_q      <= num_d;
      head_q     <= head_d;
      hold_vld_q <= hold_vld_d;
      hold_q     <= hold_d;
    end
  end

  // R8: a stalled group stays on the lanes
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_lane_vld) && $stable(out_lane_tag) &&
                                $stable(out_lane_idx) && $stable(out_lane_ucode));
  // R2: valid lanes form a prefix from lane 0
  a_r2_lane_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_lane_vld + NDEC'(1)) & out_lane_vld) == '0);
  // R1: sequencer output never exceeds the micro-op limit
  a_r1_uop_cap: assert property (@(posedge clk) disable iff (!rst_n)
    out_lane_ucode != '0 |-> $countones(out_lane_vld) <= MAXU);
  // R9: an accepted window fills the buffer
  a_r9_take: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_num != '0 |=> !in_ready);
  // R5: a fused lane never comes from the sequencer
  a_r5_fused_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_lane_fused & out_lane_ucode) == '0);
endmodule

// File: tb/decode_group_alloc_test.sv
module decode_group_alloc_test;
  localparam int CLK_NS = 10;
  localparam int NSLOT = 5, NDEC = 5, TAGW = 8, UCW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [2:0] in_num = '0;
  logic [NSLOT*TAGW-1:0] in_tag = '0;
  logic [NSLOT*UCW-1:0]  in_nuop = '0;
  logic [NSLOT-1:0] in_fus = '0, in_br = '0;
  logic [NDEC-1:0] out_lane_vld, out_lane_fused, out_lane_ucode;
  logic [NDEC*TAGW-1:0] out_lane_tag;
  logic [NDEC*UCW-1:0] out_lane_idx;
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  decode_group_alloc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_num(in_num), .in_tag(in_tag), .in_nuop(in_nuop), .in_fus(in_fus),
    .in_br(in_br), .out_valid(out_valid), .out_ready(out_ready),
    .out_lane_vld(out_lane_vld), .out_lane_tag(out_lane_tag),
    .out_lane_idx(out_lane_idx), .out_lane_fused(out_lane_fused),
    .out_lane_ucode(out_lane_ucode));

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_cnt(string r, int n);
    chk({r, " lane count"}, $countones(out_lane_vld), n);
  endtask

  // packs {tag, idx, fused, ucode} of one lane; requires the lane valid
  task automatic chk_lane(string r, int l, int tag, int idx, int fu, int uc);
    int act, exp;
    act = {out_lane_vld[l], out_lane_tag[l*TAGW +: TAGW], out_lane_idx[l*UCW +: UCW],
           out_lane_fused[l], out_lane_ucode[l]};
    exp = {1'b1, 8'(tag), 4'(idx), 1'(fu), 1'(uc)};
    chk($sformatf("%s lane%0d", r, l), act, exp);
  endtask

  task automatic clr();
    in_tag = '0; in_nuop = '0; in_fus = '0; in_br = '0;
  endtask

  task automatic put(int s, int tag, int n, bit fu, bit br);
    in_tag[s*TAGW +: TAGW] = 8'(tag);
    in_nuop[s*UCW +: UCW]  = 4'(n);
    in_fus[s] = fu;
    in_br[s]  = br;
  endtask

  task automatic send(int num);
    in_num = 3'(num);
    in_valid = 1'b1;
    while (!in_ready) step();
    step();
    in_valid = 1'b0;
    clr();
  endtask

  task automatic t_reset();
    chk("R9 reset in_ready", int'(in_ready), 1);
    chk("R9 reset out_valid", int'(out_valid), 0);
  endtask

  task automatic t_five_single();
    for (int i = 0; i < 5; i++) put(i, i + 1, 1, 0, 0);
    send(5);
    chk_cnt("R1 five singles", 5);
    for (int i = 0; i < 5; i++) chk_lane("R1", i, i + 1, 0, 0, 0);
    step();
    chk("R9 drained out_valid", int'(out_valid), 0);
    chk("R9 drained in_ready", int'(in_ready), 1);
  endtask

  task automatic t_multi();
    put(0, 10, 2, 0, 0); put(1, 11, 1, 0, 0); put(2, 12, 1, 0, 0);
    put(3, 13, 1, 0, 0); put(4, 14, 3, 0, 0);
    send(5);
    chk_cnt("R3 2-1-1", 4);
    chk_lane("R2", 0, 10, 0, 0, 0); chk_lane("R2", 1, 10, 1, 0, 0);
    chk_lane("R3", 2, 11, 0, 0, 0); chk_lane("R3", 3, 12, 0, 0, 0);
    step();
    chk_cnt("R2 multi ends group", 1);
    chk_lane("R2", 0, 13, 0, 0, 0);
    step();
    chk_cnt("R2 multi leads", 3);
    for (int i = 0; i < 3; i++) chk_lane("R2", i, 14, i, 0, 0);
    step();
  endtask

  task automatic t_ucode();
    put(0, 20, 10, 0, 0); put(1, 21, 1, 0, 0);
    send(2);
    chk_cnt("R4 first chunk", 4);
    for (int i = 0; i < 4; i++) chk_lane("R4", i, 20, i, 0, 1);
    step();
    chk_cnt("R4 second chunk", 4);
    for (int i = 0; i < 4; i++) chk_lane("R4", i, 20, i + 4, 0, 1);
    step();
    chk_cnt("R4 remainder", 2);
    chk_lane("R4", 0, 20, 8, 0, 1); chk_lane("R4", 1, 20, 9, 0, 1);
    step();
    chk_cnt("R4 decoders resume", 1);
    chk_lane("R4", 0, 21, 0, 0, 0);
    step();
    put(0, 25, 1, 0, 0); put(1, 26, 6, 0, 0);
    send(2);
    chk_cnt("R4 long not in slot1", 1);
    chk_lane("R4", 0, 25, 0, 0, 0);
    step();
    chk_cnt("R4 long leads", 4);
    chk_lane("R4", 3, 26, 3, 0, 1);
    step();
    chk_cnt("R4 long tail", 2);
    chk_lane("R4", 1, 26, 5, 0, 1);
    step();
  endtask

  task automatic t_fuse_in_window();
    put(0, 30, 1, 1, 0); put(1, 31, 1, 0, 1); put(2, 32, 1, 0, 0); put(3, 33, 1, 0, 0);
    send(4);
    chk_cnt("R5 fused pair one lane", 3);
    chk_lane("R5", 0, 30, 0, 1, 0);
    chk_lane("R5", 1, 32, 0, 0, 0);
    chk_lane("R5", 2, 33, 0, 0, 0);
    step();
  endtask

  task automatic t_hold_cross();
    put(0, 40, 1, 0, 0); put(1, 41, 1, 1, 0);
    send(2);
    chk_cnt("R6 fusible at end held", 1);
    chk_lane("R6", 0, 40, 0, 0, 0);
    step();
    chk("R6 held alone out_valid", int'(out_valid), 0);
    chk("R6 held alone in_ready", int'(in_ready), 1);
    put(0, 42, 1, 0, 1); put(1, 43, 1, 0, 0);
    send(2);
    chk_cnt("R6 fuse across windows", 2);
    chk_lane("R6", 0, 41, 0, 1, 0);
    chk_lane("R6", 1, 43, 0, 0, 0);
    step();
  endtask

  task automatic t_hold_release();
    put(0, 50, 1, 1, 0);
    send(1);
    chk("R7 held lone out_valid", int'(out_valid), 0);
    put(0, 51, 1, 0, 0); put(1, 52, 1, 0, 0);
    send(2);
    chk_cnt("R7 released group", 3);
    chk_lane("R7", 0, 50, 0, 0, 0);
    chk_lane("R7", 1, 51, 0, 0, 0);
    chk_lane("R7", 2, 52, 0, 0, 0);
    step();
    put(0, 60, 3, 0, 0); put(1, 61, 1, 1, 0); put(2, 62, 1, 0, 0);
    send(3);
    chk_cnt("R6 held at cap", 3);
    chk_lane("R6", 2, 60, 2, 0, 0);
    step();
    chk_cnt("R7 held heads group", 2);
    chk_lane("R7", 0, 61, 0, 0, 0);
    chk_lane("R7", 1, 62, 0, 0, 0);
    step();
  endtask

  task automatic t_backpressure();
    put(0, 70, 1, 0, 0); put(1, 71, 1, 0, 0);
    send(2);
    out_ready = 1'b0;
    chk_cnt("R8 before stall", 2);
    step();
    step();
    chk_cnt("R8 stalled", 2);
    chk_lane("R8", 0, 70, 0, 0, 0);
    chk_lane("R8", 1, 71, 0, 0, 0);
    chk("R8 nothing consumed", int'(in_ready), 0);
    out_ready = 1'b1;
    step();
    chk("R8 released", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_five_single();
    t_multi();
    t_ucode();
    t_fuse_in_window();
    t_hold_cross();
    t_hold_release();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule